// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter

This unit sits in every processing node that shares one external bus with up to five peer nodes and one host. Each node drives exactly one active-low bus-request line, chosen by its node ID, and observes all six request lines. Identical copies of the arbiter see the same request lines, the same host request and the same shared core-priority line. Each copy clocks the same owner decision into a local owner register on the same edge, so no central arbiter is needed. The owner decision uses lowest-ID-first priority, or a rotating order that starts after the last granted node.

The holder of the bus keeps it while its request line stays low. A host request takes the bus once the holder lets go. A bus lock stops the holder from letting go, which keeps read-modify-write sequences indivisible. A shared core-priority line asks a holder doing background transfers to step aside. Node ID 0 denotes a stand-alone processor: line-based arbitration is bypassed and only the host can take the bus from it. Open-drain and three-state behaviour is modelled as plain wired-AND logic outside the block.

Top module: `mpa_node`

## Requirements
- R1: After reset, `owner_id` is 0, `is_master` is low, `host_grant_n` is high and `br_n_out` is high.
- R2: A node with nonzero ID k drives `br_n_out` low exactly when `want_bus` is high and it is not yielding (R7, R9). It reads node k's line as bit k-1 of `br_n_in`, so bit 0 belongs to ID 1.
- R3: With `rot_pri` low, free arbitration grants the lowest requesting ID. Arbitration is free when the bus is idle, the holder's line is high, or the host has just released the bus.
- R4: With `rot_pri` high, free arbitration searches IDs upward from the one after the last granted ID, wrapping from 6 to 1. Reset treats ID 6 as last granted.
- R5: The owner is unchanged on every edge where the owner's request line is low. On the first edge where that line is seen high, a new owner (or 0) is taken and reported in the following cycle.
- R6: A low `host_req_n` is served on any edge where the bus is free. The node then drives `host_grant_n` low and `owner_id` 0, and keeps both until `host_req_n` is seen high. On that same edge it arbitrates among the node requests.
- R7: A master with `lock_req` low raises its request line while `host_req_n` is low.
- R8: A master with `lock_req` high keeps its request line low while it wants the bus, even when the host or the core-priority line claims it.
- R9: A non-master node that has `want_bus` and `core_urgent` high pulls `cpa_n_out` low. A master with `lock_req` low and `core_urgent` low raises its request line while `cpa_n_in` is low.
- R10: With node ID 0, `br_n_out` and `cpa_n_out` stay high and `owner_id` stays 0. `is_master` is high unless the host holds the bus. The host is granted on an edge where `host_req_n` is low and `lock_req` is low.
- R11: For a nonzero node ID, `is_master` is high exactly when `owner_id` equals the node ID and the host does not hold the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| node_id | input | 3 | Node ID, 0 for stand-alone, 1..6 otherwise; change only in reset |
| rot_pri | input | 1 | 1 = rotating priority, 0 = fixed priority |
| want_bus | input | 1 | Local logic needs the bus |
| lock_req | input | 1 | Hold mastership for an indivisible sequence |
| core_urgent | input | 1 | Current or pending transfer belongs to the core, not background DMA |
| br_n_in | input | 6 | Wired request lines of all nodes, active low, bit k-1 = ID k |
| br_n_out | output | 1 | This node's request line drive, active low |
| cpa_n_in | input | 1 | Wired core-priority line, active low |
| cpa_n_out | output | 1 | This node's core-priority drive, active low |
| host_req_n | input | 1 | Host bus request, active low |
| host_grant_n | output | 1 | Host bus grant, active low |
| is_master | output | 1 | This node owns the bus |
| owner_id | output | 3 | ID of the current bus owner, 0 for none or host |

## Verification
The bench builds the block with its default of six nodes and a 3-bit ID. This puts the wrap of the rotating search from ID 6 back to ID 1 within reach, as well as requests on every line. The device under test runs as node 3, so lines both below and above its own ID compete with it. A second phase resets it with ID 0 to cover the stand-alone path. The other five nodes, the host and the core-priority line are random. Directed sequences pin the fixed and rotating grant orders, and the lock against a host request.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    localparam int unsigned DEF_NODES = 6;

    // bus state shared by every node's tracker
    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_NODE = 2'd1,
        BUS_HOST = 2'd2
    } bus_mode_e;

    // next position in the circular ID order 1..n
    function automatic int unsigned next_id(input int unsigned cur, input int unsigned n);
        return (cur >= n) ? 1 : cur + 1;
    endfunction

endpackage

// File: rtl/mpa_pick.sv
module mpa_pick #(
    parameter int unsigned NODES = 6,
    parameter int unsigned IDW   = 3
) (
    input  logic [NODES-1:0] req,
    input  logic [IDW-1:0]   last_id,
    input  logic             rot_pri,
    output logic [IDW-1:0]   win
);
    import mpa_pkg::*;

    always_comb begin
        int unsigned cand;
        logic        found;
        // fixed priority is the rotating search started after the top ID
        cand  = rot_pri ? int'(last_id) : NODES;
        win   = '0;
        found = 1'b0;
        for (int k = 0; k < NODES; k++) begin
            cand = next_id(cand, NODES);
            if (!found && req[cand-1]) begin
                win   = IDW'(cand);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mpa_track.sv
module mpa_track #(
    parameter int unsigned NODES = 6,
    parameter int unsigned IDW   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              single,
    input  logic [NODES-1:0]  req,
    input  logic              host_req,
    input  logic              lock_req,
    input  logic [IDW-1:0]    win,
    output mpa_pkg::bus_mode_e mode,
    output logic [IDW-1:0]    owner,
    output logic [IDW-1:0]    last_id
);
    import mpa_pkg::*;

    bus_mode_e       n_mode;
    logic [IDW-1:0]  n_owner;
    logic [IDW-1:0]  n_last;
    logic            held;

    always_comb begin
        held = 1'b0;
        if (mode == BUS_NODE && owner != '0)
            held = req[owner - IDW'(1)];
    end

    always_comb begin
        n_mode  = mode;
        n_owner = owner;
        n_last  = last_id;
        if (single) begin
            n_owner = '0;
            if (mode == BUS_HOST) begin
                if (!host_req) n_mode = BUS_IDLE;
            end else if (host_req && !lock_req) begin
                n_mode = BUS_HOST;
            end else begin
                n_mode = BUS_IDLE;
            end
        end else if (mode == BUS_HOST) begin
            if (!host_req) begin
                n_mode  = (win != '0) ? BUS_NODE : BUS_IDLE;
                n_owner = win;
                if (win != '0) n_last = win;
            end
        end else if (!held) begin
            if (host_req) begin
                n_mode  = BUS_HOST;
                n_owner = '0;
            end else begin
                n_mode  = (win != '0) ? BUS_NODE : BUS_IDLE;
                n_owner = win;
                if (win != '0) n_last = win;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= BUS_IDLE;
            owner   <= '0;
            last_id <= IDW'(NODES);
        end else begin
            mode    <= n_mode;
            owner   <= n_owner;
            last_id <= n_last;
        end
    end

endmodule

// File: rtl/mpa_drive.sv
module mpa_drive #(
    parameter int unsigned IDW = 3
) (
    input  logic               single,
    input  logic [IDW-1:0]     node_id,
    input  mpa_pkg::bus_mode_e mode,
    input  logic [IDW-1:0]     owner,
    input  logic               want_bus,
    input  logic               lock_req,
    input  logic               core_urgent,
    input  logic               host_req,
    input  logic               cpa_low,
    output logic               is_master,
    output logic               br_n_out,
    output logic               cpa_n_out,
    output logic               host_grant_n
);
    import mpa_pkg::*;

    logic yield_bus;

    always_comb begin
        if (single) is_master = (mode != BUS_HOST);
        else        is_master = (mode == BUS_NODE) && (owner == node_id);
        yield_bus    = is_master && !lock_req &&
                       (host_req || (cpa_low && !core_urgent));
        br_n_out     = single || !(want_bus && !yield_bus);
        cpa_n_out    = single || !(want_bus && core_urgent && !is_master);
        host_grant_n = (mode != BUS_HOST);
    end

endmodule

// File: rtl/mpa_node.sv
module mpa_node #(
    parameter int unsigned NODES = mpa_pkg::DEF_NODES,
    localparam int unsigned IDW  = $clog2(NODES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDW-1:0]   node_id,
    input  logic             rot_pri,
    input  logic             want_bus,
    input  logic             lock_req,
    input  logic             core_urgent,
    input  logic [NODES-1:0] br_n_in,
    output logic             br_n_out,
    input  logic             cpa_n_in,
    output logic             cpa_n_out,
    input  logic             host_req_n,
    output logic             host_grant_n,
    output logic             is_master,
    output logic [IDW-1:0]   owner_id
);
    import mpa_pkg::*;

    logic [NODES-1:0] req;
    logic [IDW-1:0]   win;
    logic [IDW-1:0]   last_id;
    bus_mode_e        mode;
    logic             single;

    assign single = (node_id == '0);

    for (genvar g = 0; g < NODES; g++) begin : g_req
        assign req[g] = !br_n_in[g];
    end

    mpa_pick #(.NODES(NODES), .IDW(IDW)) u_pick (
        .req     (req),
        .last_id (last_id),
        .rot_pri (rot_pri),
        .win     (win)
    );

    mpa_track #(.NODES(NODES), .IDW(IDW)) u_track (
        .clk      (clk),
        .rst      (rst),
        .single   (single),
        .req      (req),
        .host_req (!host_req_n),
        .lock_req (lock_req),
        .win      (win),
        .mode     (mode),
        .owner    (owner_id),
        .last_id  (last_id)
    );

    mpa_drive #(.IDW(IDW)) u_drive (
        .single       (single),
        .node_id      (node_id),
        .mode         (mode),
        .owner        (owner_id),
        .want_bus     (want_bus),
        .lock_req     (lock_req),
        .core_urgent  (core_urgent),
        .host_req     (!host_req_n),
        .cpa_low      (!cpa_n_in),
        .is_master    (is_master),
        .br_n_out     (br_n_out),
        .cpa_n_out    (cpa_n_out),
        .host_grant_n (host_grant_n)
    );

endmodule

// File: rtl/mpa_node_chk.sv
module mpa_node_chk #(
    parameter int unsigned NODES = 6,
    parameter int unsigned IDW   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [IDW-1:0]   node_id,
    input logic             rot_pri,
    input logic             want_bus,
    input logic             lock_req,
    input logic [NODES-1:0] br_n_in,
    input logic             br_n_out,
    input logic             cpa_n_out,
    input logic             host_req_n,
    input logic             host_grant_n,
    input logic             is_master,
    input logic [IDW-1:0]   owner_id
);

    p_host_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (!host_grant_n && !host_req_n) |=> !host_grant_n)
        else $error("p_host_stays_r6");

    p_host_no_owner_r6: assert property (@(posedge clk) disable iff (rst)
        (node_id != '0 && !host_grant_n) |-> (owner_id == '0 && !is_master))
        else $error("p_host_no_owner_r6");

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (node_id != '0 && owner_id != '0 && host_grant_n &&
         !br_n_in[owner_id - IDW'(1)]) |=> (owner_id == $past(owner_id)))
        else $error("p_hold_r5");

    p_lock_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (node_id != '0 && is_master && lock_req && want_bus) |-> !br_n_out)
        else $error("p_lock_keeps_r8");

    p_single_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (node_id == '0) |-> (br_n_out && cpa_n_out && owner_id == '0))
        else $error("p_single_quiet_r10");

    p_fixed_grants_r3: assert property (@(posedge clk) disable iff (rst)
        (node_id != '0 && owner_id == '0 && host_grant_n && host_req_n &&
         !rot_pri && br_n_in != '1) |=> (owner_id != '0))
        else $error("p_fixed_grants_r3");

    p_master_id_r11: assert property (@(posedge clk) disable iff (rst)
        (node_id != '0 && is_master) |-> (owner_id == node_id))
        else $error("p_master_id_r11");

endmodule

bind mpa_node mpa_node_chk #(.NODES(NODES), .IDW(IDW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .node_id      (node_id),
    .rot_pri      (rot_pri),
    .want_bus     (want_bus),
    .lock_req     (lock_req),
    .br_n_in      (br_n_in),
    .br_n_out     (br_n_out),
    .cpa_n_out    (cpa_n_out),
    .host_req_n   (host_req_n),
    .host_grant_n (host_grant_n),
    .is_master    (is_master),
    .owner_id     (owner_id)
);

// File: tb/tb_mpa_node.sv
`timescale 1ns/1ps
module tb_mpa_node;

    localparam int N = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] node_id = 3'd3;
    logic       rot_pri = 1'b0;
    logic       want_bus = 1'b0, lock_req = 1'b0, core_urgent = 1'b0;
    logic [N-1:0] o_req = '0;     // other nodes' requests, active high
    logic       o_cpa_n = 1'b1;
    logic       host_req_n = 1'b1;
    logic [N-1:0] br_line;
    logic       cpa_line;
    logic       br_n_out, cpa_n_out, host_grant_n, is_master;
    logic [2:0] owner_id;

    int checks = 0;
    int errors = 0;

    // model state: 0 idle, 1 node, 2 host
    int m_mode = 0, m_own = 0, m_last = N;
    int p_mode = 0, p_own = 0, p_last = N;

    always #10 clk = ~clk;

    always_comb begin
        br_line = ~o_req;
        if (node_id != 3'd0) br_line[node_id-1] = br_n_out;
    end
    assign cpa_line = o_cpa_n & cpa_n_out;

    mpa_node dut (
        .clk(clk), .rst(rst), .node_id(node_id), .rot_pri(rot_pri),
        .want_bus(want_bus), .lock_req(lock_req), .core_urgent(core_urgent),
        .br_n_in(br_line), .br_n_out(br_n_out), .cpa_n_in(cpa_line),
        .cpa_n_out(cpa_n_out), .host_req_n(host_req_n),
        .host_grant_n(host_grant_n), .is_master(is_master), .owner_id(owner_id)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pick(input logic [N-1:0] rq, input int last, input logic rot);
        int c;
        c = rot ? last : N;
        for (int k = 0; k < N; k++) begin
            c = (c >= N) ? 1 : c + 1;
            if (rq[c-1]) return c;
        end
        return 0;
    endfunction

    // drive at negedge, check combos, step model, check registers at next negedge
    task automatic cyc();
        bit sgl, ism, yld, eb, ec, host, held;
        int w;
        logic [N-1:0] rq;
        string btag;
        sgl  = (node_id == 0);
        host = !host_req_n;
        ism  = sgl ? (m_mode != 2) : (m_mode == 1 && m_own == node_id);
        ec   = sgl || !(want_bus && core_urgent && !ism);
        yld  = ism && !lock_req && (host || (!(o_cpa_n && ec) && !core_urgent));
        eb   = sgl || !(want_bus && !yld);
        #1;
        btag = sgl ? "R10" : (ism && lock_req) ? "R8" : (yld && host) ? "R7" : yld ? "R9" : "R2";
        chk(btag, br_n_out, eb);
        chk(sgl ? "R10" : "R9", cpa_n_out, ec);
        rq = ~br_line;
        w  = pick(rq, m_last, rot_pri);
        p_mode = m_mode; p_own = m_own; p_last = m_last;
        if (sgl) begin
            p_own = 0;
            if (m_mode == 2) begin if (!host) p_mode = 0; end
            else p_mode = (host && !lock_req) ? 2 : 0;
        end else begin
            held = (m_mode == 1) && m_own != 0 && rq[m_own-1];
            if ((m_mode == 2 && !host) || (m_mode != 2 && !held && !host)) begin
                p_mode = (w != 0) ? 1 : 0; p_own = w;
                if (w != 0) p_last = w;
            end else if (m_mode != 2 && !held && host) begin
                p_mode = 2; p_own = 0;
            end
        end
        @(negedge clk);
        m_mode = p_mode; m_own = p_own; m_last = p_last;
        sgl = (node_id == 0);
        chk(sgl ? "R10" : (rot_pri ? "R4" : "R3"), owner_id, m_own);
        chk("R6", host_grant_n, m_mode != 2);
        chk(sgl ? "R10" : "R11", is_master,
            sgl ? (m_mode != 2) : (m_mode == 1 && m_own == node_id));
    endtask

    task automatic do_reset(input logic [2:0] id);
        @(negedge clk);
        rst = 1'b1; node_id = id; o_req = '0; want_bus = 0; lock_req = 0;
        core_urgent = 0; host_req_n = 1; o_cpa_n = 1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_mode = 0; m_own = 0; m_last = N;
    endtask

    task automatic rand_run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            for (int b = 0; b < N; b++)
                if ($urandom_range(7) == 0) o_req[b] = ~o_req[b];
            if ($urandom_range(3) == 0) want_bus = ~want_bus;
            if ($urandom_range(9) == 0) lock_req = ~lock_req;
            if ($urandom_range(5) == 0) core_urgent = ~core_urgent;
            o_cpa_n = ($urandom_range(9) != 0);
            if ($urandom_range(29) == 0) host_req_n = ~host_req_n;
            if ($urandom_range(199) == 0) rot_pri = ~rot_pri;
            cyc();
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        do_reset(3'd3);
        // R1: reset state
        #1;
        chk("R1", owner_id, 0);
        chk("R1", is_master, 0);
        chk("R1", host_grant_n, 1);
        chk("R1", br_n_out, 1);

        // R3: fixed priority, IDs 1,3,5 requesting -> 1
        rot_pri = 0; o_req = 6'b010001; want_bus = 1;
        cyc();
        chk("R3", owner_id, 1);
        // R5: holder keeps bus while its line stays low
        cyc();
        chk("R5", owner_id, 1);
        // holder drops, 3 wins over 5
        o_req = 6'b010000;
        cyc();
        chk("R3", owner_id, 3);
        chk("R11", is_master, 1);

        // R4: rotating order after reset
        do_reset(3'd3);
        rot_pri = 1; o_req = 6'b010001; want_bus = 1;
        cyc();
        chk("R4", owner_id, 1);
        o_req = 6'b010000;
        cyc();
        chk("R4", owner_id, 3);
        want_bus = 0; o_req = 6'b010001;
        cyc();
        chk("R4", owner_id, 5);
        want_bus = 1; o_req = 6'b000001;
        cyc();
        chk("R4", owner_id, 1);   // search from 6 wraps to 1 before 3

        // R8 / R7 / R6: lock against host
        do_reset(3'd3);
        rot_pri = 0; want_bus = 1;
        cyc();
        chk("R11", owner_id, 3);
        lock_req = 1; host_req_n = 0;
        cyc();
        chk("R8", br_n_out, 0);
        chk("R8", owner_id, 3);
        lock_req = 0;
        #1;
        chk("R7", br_n_out, 1);
        cyc();
        chk("R6", host_grant_n, 0);
        chk("R6", owner_id, 0);
        cyc();
        chk("R6", host_grant_n, 0);
        host_req_n = 1;
        cyc();
        chk("R6", owner_id, 3);

        rand_run(6000);

        // R10: stand-alone node
        do_reset(3'd0);
        #1;
        chk("R10", is_master, 1);
        rand_run(3000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule